// File: doc/BRIEF.md
# Cartridge ROM Block Transfer Controller

This block sits on the host side of a cartridge slot and runs block reads from the cartridge ROM. The host writes an eight-byte command together with a control word. The control word holds a three-bit block-size code, a rate bit and a start bit. Once started, the controller decodes the command and, for a data read, fetches 32-bit words from a ROM model port one at a time. Each word appears in a data register with a word-ready flag. The controller paces every fetch so that it follows the previous host read of the data register by a fixed number of cycles.

Each delivered word can pulse a DMA request. At the end of the block the data register reads zero and busy drops. An optional interrupt pulse marks completion, and a second pulse tells a non-repeating DMA channel to drop its enable. A chip-identification command returns a fixed word without any ROM traffic. Any other opcode finishes as an empty block.

The control is a three-state machine:
- `ST_IDLE` waits for a start.
- `ST_PACE` counts the pacing delay.
- `ST_PRESENT` holds a word until the host reads it.

The machine has these transitions:
- launch (`ST_IDLE` to `ST_PACE`, or straight to `ST_PRESENT` for chip ID).
- fetch (`ST_PACE` to `ST_PRESENT` when bytes remain).
- finish (`ST_PACE` to `ST_IDLE` when none remain).
- consume (`ST_PRESENT` to `ST_PACE` on a data read).
- relaunch (any busy state to the launch target on a new start).

Top module: `cart_rom_xfer`

## Requirements
- R1: After reset, busy, word_ready, irq, dma_req and dma_off are 0 and data_out is 0.
- R2: The block length in bytes is 0 for size code 0, 4 for code 7, and 256 shifted left by n for any other code n; a read delivers that many bytes divided by four words.
- R3: Opcode 0xB7 (command byte 0 at cmd_in[7:0]) starts a read. Its start address is bytes 1 to 4, where byte k sits at cmd_in[8k+7:8k] and byte 1 is most significant. Word k of the block is the ROM word at start + 4k.
- R4: A read start address below 0x8000 is replaced by 0x8000 plus its low 9 bits; an address of 0x8000 or above is used unchanged.
- R5: Opcode 0xB8 sets word_ready and busy, with data_out equal to the CHIP_ID parameter, on the edge that takes the start. It pulses no rom_rd. The block ends one pacing delay after the host's data read.
- R6: The pacing delay D is 5 cycles with ctl_rate=0 and 8 with ctl_rate=1, and it doubles when sec_owns=0. A fetch or an end takes effect exactly D clock edges after the edge that accepted the start or the data_rd.
- R7: On each delivered word, word_ready rises, rom_addr advances by 4, and dma_req pulses for one cycle when dma_en=1. A data_rd clears word_ready on the next edge.
- R8: At the end of a block, data_out becomes 0 and word_ready and busy both clear. irq pulses for one cycle if irq_en=1, and dma_off pulses if dma_en=1 and dma_repeat=0.
- R9: A start while spi_mode=1 is ignored: busy and word_ready stay 0.
- R10: A start accepted while busy abandons the current block and launches the newly loaded command.
- R11: An opcode other than 0xB7 or 0xB8 sets busy without word_ready, pulses no rom_rd, and ends as an empty block D edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_in | input | 64 | Eight command bytes, byte k at bits 8k+7:8k |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_size | input | 3 | Block-size code |
| ctl_rate | input | 1 | Slow-rate select (8-cycle base) |
| ctl_start | input | 1 | Start bit of the control word |
| spi_mode | input | 1 | Auxiliary port is in serial mode; blocks starts |
| sec_owns | input | 1 | Secondary processor owns the slot (undoubled delay) |
| irq_en | input | 1 | Enable completion interrupt |
| dma_en | input | 1 | Slot-triggered DMA channel enabled |
| dma_repeat | input | 1 | That DMA channel repeats |
| data_rd | input | 1 | Host read strobe of the data register |
| data_out | output | 32 | Data register |
| word_ready | output | 1 | A word is waiting in data_out |
| busy | output | 1 | Block in progress |
| rom_addr | output | 32 | ROM word address |
| rom_rd | output | 1 | ROM fetch strobe (rom_data sampled this edge) |
| rom_data | input | 32 | ROM word at rom_addr |
| irq | output | 1 | Completion interrupt pulse |
| dma_req | output | 1 | Per-word DMA request pulse |
| dma_off | output | 1 | Clear-enable pulse for a non-repeating DMA channel |

## Verification
The assertions expect strobes that are one cycle wide and never X. They also expect rom_data to be a function of rom_addr within the same cycle. The stimulus drives every strobe for exactly one clock between falling edges. It issues data_rd only while a word is presented, and it drives the ROM port from an arithmetic function of the address. Configuration inputs change only while the block is idle, except in the restart case. That case starts a fresh block on purpose while a word is still presented.

// File: rtl/cart_rom_pkg.sv
package cart_rom_pkg;

    // widest block is 256 << 6 bytes
    localparam int BYTES_W = 15;

    localparam logic [7:0] OPC_DATA_READ = 8'hB7;
    localparam logic [7:0] OPC_CHIP_ID   = 8'hB8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PACE,
        ST_PRESENT
    } xfer_state_t;

    typedef enum logic [1:0] {
        OP_READ,
        OP_CHIPID,
        OP_OTHER
    } op_kind_t;

    function automatic logic [BYTES_W-1:0] block_bytes(input logic [2:0] code);
        logic [BYTES_W-1:0] n;
        if (code == 3'd0)
            n = '0;
        else if (code == 3'd7)
            n = BYTES_W'(4);
        else
            n = BYTES_W'(256) << code;
        return n;
    endfunction

endpackage

// File: rtl/cart_cmd_decode.sv
module cart_cmd_decode
    import cart_rom_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] LIMIT    = 32'h0000_8000,
    parameter int          WIN_BITS = 9
) (
    input  logic [63:0]        cmd,
    input  logic [2:0]         size_code,
    output op_kind_t           kind,
    output logic [ADDR_W-1:0]  start_addr,
    output logic [BYTES_W-1:0] byte_count
);

    localparam logic [ADDR_W-1:0] LIM = ADDR_W'(LIMIT);

    logic [ADDR_W-1:0] req_addr;
    logic              unused_tail;

    assign unused_tail = ^cmd[63:40];
    assign req_addr    = ADDR_W'({cmd[15:8], cmd[23:16], cmd[31:24], cmd[39:32]});

    always_comb begin
        unique case (cmd[7:0])
            OPC_DATA_READ: kind = OP_READ;
            OPC_CHIP_ID:   kind = OP_CHIPID;
            default:       kind = OP_OTHER;
        endcase
    end

    always_comb begin
        if (req_addr < LIM)
            start_addr = LIM + ADDR_W'(req_addr[WIN_BITS-1:0]);
        else
            start_addr = req_addr;
    end

    assign byte_count = block_bytes(size_code);

endmodule

// File: rtl/cart_pace_timer.sv
module cart_pace_timer #(
    parameter int FAST = 5,
    parameter int SLOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rate,
    input  logic owned,
    output logic tick
);

    localparam int MAXB = (SLOW > FAST) ? SLOW : FAST;
    localparam int MAXD = 2 * MAXB;
    localparam int DW   = $clog2(MAXD + 1);

    logic [DW-1:0] cnt_q;
    logic          run_q;
    logic [DW-1:0] base;
    logic [DW-1:0] dly;

    assign base = rate ? DW'(SLOW) : DW'(FAST);
    assign dly  = owned ? base : (base << 1);
    assign tick = run_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= dly - 1'b1;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> !tick); // R6

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < DW'(MAXD))); // R6

endmodule

// File: rtl/cart_rom_xfer.sv
module cart_rom_xfer
    import cart_rom_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] LIMIT    = 32'h0000_8000,
    parameter int          WIN_BITS = 9,
    parameter int          FAST     = 5,
    parameter int          SLOW     = 8,
    parameter logic [31:0] CHIP_ID  = 32'h0000_3FC2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       cmd_in,
    input  logic              ctl_wr,
    input  logic [2:0]        ctl_size,
    input  logic              ctl_rate,
    input  logic              ctl_start,
    input  logic              spi_mode,
    input  logic              sec_owns,
    input  logic              irq_en,
    input  logic              dma_en,
    input  logic              dma_repeat,
    input  logic              data_rd,
    output logic [31:0]       data_out,
    output logic              word_ready,
    output logic              busy,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [31:0]       rom_data,
    output logic              irq,
    output logic              dma_req,
    output logic              dma_off
);

    xfer_state_t        st_q, st_nx, launch_st;
    op_kind_t           dec_kind;
    logic [ADDR_W-1:0]  dec_addr;
    logic [BYTES_W-1:0] dec_bytes;

    logic [ADDR_W-1:0]  addr_q;
    logic [BYTES_W-1:0] rem_q;
    logic [31:0]        data_q;
    logic               ready_q, busy_q, irq_q, dreq_q, doff_q;

    logic start_ok, consume, tick, load, fetch, finish;

    cart_cmd_decode #(
        .ADDR_W   (ADDR_W),
        .LIMIT    (LIMIT),
        .WIN_BITS (WIN_BITS)
    ) u_dec (
        .cmd        (cmd_in),
        .size_code  (ctl_size),
        .kind       (dec_kind),
        .start_addr (dec_addr),
        .byte_count (dec_bytes)
    );

    assign start_ok  = ctl_wr && ctl_start && !spi_mode;
    assign consume   = (st_q == ST_PRESENT) && data_rd && !start_ok;
    assign launch_st = (dec_kind == OP_CHIPID) ? ST_PRESENT : ST_PACE;
    assign load      = (start_ok && dec_kind != OP_CHIPID) || consume;

    cart_pace_timer #(
        .FAST (FAST),
        .SLOW (SLOW)
    ) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .rate  (ctl_rate),
        .owned (sec_owns),
        .tick  (tick)
    );

    assign fetch  = (st_q == ST_PACE) && tick && !start_ok && (rem_q != '0);
    assign finish = (st_q == ST_PACE) && tick && !start_ok && (rem_q == '0);

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_ok) st_nx = launch_st;
            end
            ST_PACE: begin
                if (start_ok)    st_nx = launch_st;
                else if (fetch)  st_nx = ST_PRESENT;
                else if (finish) st_nx = ST_IDLE;
            end
            ST_PRESENT: begin
                if (start_ok)     st_nx = launch_st;
                else if (data_rd) st_nx = ST_PACE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            data_q  <= '0;
            ready_q <= 1'b0;
            busy_q  <= 1'b0;
            irq_q   <= 1'b0;
            dreq_q  <= 1'b0;
            doff_q  <= 1'b0;
        end else begin
            irq_q  <= 1'b0;
            dreq_q <= 1'b0;
            doff_q <= 1'b0;
            if (start_ok) begin
                busy_q <= 1'b1;
                addr_q <= dec_addr;
                rem_q  <= (dec_kind == OP_READ) ? dec_bytes : '0;
                if (dec_kind == OP_CHIPID) begin
                    data_q  <= CHIP_ID;
                    ready_q <= 1'b1;
                end else begin
                    ready_q <= 1'b0;
                end
            end else if (fetch) begin
                data_q  <= rom_data;
                addr_q  <= addr_q + ADDR_W'(4);
                rem_q   <= rem_q - BYTES_W'(4);
                ready_q <= 1'b1;
                dreq_q  <= dma_en;
            end else if (finish) begin
                data_q  <= '0;
                ready_q <= 1'b0;
                busy_q  <= 1'b0;
                irq_q   <= irq_en;
                doff_q  <= dma_en && !dma_repeat;
            end else if (consume) begin
                ready_q <= 1'b0;
            end
        end
    end

    assign data_out   = data_q;
    assign word_ready = ready_q;
    assign busy       = busy_q;
    assign rom_addr   = addr_q;
    assign rom_rd     = fetch;
    assign irq        = irq_q;
    assign dma_req    = dreq_q;
    assign dma_off    = doff_q;

    AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> busy); // R8

    AST_SPI_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && ctl_start && spi_mode) |=> !busy); // R9

    AST_FETCH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> (rom_addr >= ADDR_W'(LIMIT))); // R4

    AST_FETCH_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> (word_ready && rom_addr == $past(rom_addr) + ADDR_W'(4))); // R7

    AST_DMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req); // R7

    AST_END_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && !word_ready && data_out == '0)); // R8

endmodule

// File: tb/sim_cart_rom_xfer.sv
module sim_cart_rom_xfer;

    localparam logic [31:0] CHIP = 32'h0000_3FC2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cmd_in = '0;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_size = '0;
    logic        ctl_rate = 1'b0;
    logic        ctl_start = 1'b0;
    logic        spi_mode = 1'b0;
    logic        sec_owns = 1'b1;
    logic        irq_en = 1'b0;
    logic        dma_en = 1'b0;
    logic        dma_repeat = 1'b0;
    logic        data_rd = 1'b0;
    logic [31:0] data_out;
    logic        word_ready;
    logic        busy;
    logic [31:0] rom_addr;
    logic        rom_rd;
    logic [31:0] rom_data;
    logic        irq;
    logic        dma_req;
    logic        dma_off;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    assign rom_data = rom_addr * 32'h0001_0003 + 32'h1234_5678;

    cart_rom_xfer u0 (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .ctl_wr(ctl_wr),
        .ctl_size(ctl_size), .ctl_rate(ctl_rate), .ctl_start(ctl_start),
        .spi_mode(spi_mode), .sec_owns(sec_owns), .irq_en(irq_en),
        .dma_en(dma_en), .dma_repeat(dma_repeat), .data_rd(data_rd),
        .data_out(data_out), .word_ready(word_ready), .busy(busy),
        .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_data(rom_data),
        .irq(irq), .dma_req(dma_req), .dma_off(dma_off)
    );

    function automatic logic [31:0] rom_word(input logic [31:0] a);
        return a * 32'h0001_0003 + 32'h1234_5678;
    endfunction

    function automatic logic [31:0] eff_start(input logic [31:0] a);
        return (a < 32'h8000) ? (32'h8000 + (a & 32'h1FF)) : a;
    endfunction

    function automatic int pace(input logic rate, input logic own);
        return (rate ? 8 : 5) * (own ? 1 : 2);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue_start(input logic [7:0] opc, input logic [31:0] a,
                               input logic [2:0] code, input logic rate);
        cmd_in    = {24'h0, a[7:0], a[15:8], a[23:16], a[31:24], opc};
        ctl_size  = code;
        ctl_rate  = rate;
        ctl_start = 1'b1;
        ctl_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ctl_wr    = 1'b0;
        ctl_start = 1'b0;
    endtask

    task automatic do_read();
        data_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        data_rd = 1'b0;
        chk(word_ready == 1'b0, "R7 ready cleared by read", 32'(word_ready), 32'd0);
    endtask

    task automatic wait_word(input int d);
        repeat (d - 1) @(posedge clk);
        @(negedge clk);
        chk(word_ready == 1'b0, "R6 word not before D edges", 32'(word_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(word_ready == 1'b1, "R6 word after D edges", 32'(word_ready), 32'd1);
    endtask

    task automatic wait_end(input int d, input logic ie, input logic de, input logic rp);
        repeat (d - 1) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy held until D edges", 32'(busy), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy cleared", 32'(busy), 32'd0);
        chk(word_ready == 1'b0, "R8 ready cleared", 32'(word_ready), 32'd0);
        chk(data_out == 32'h0, "R8 data zero", data_out, 32'h0);
        chk(irq == ie, "R8 irq pulse", 32'(irq), 32'(ie));
        chk(dma_off == (de && !rp), "R8 dma_off pulse", 32'(dma_off), 32'(de && !rp));
        @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b0 && dma_off == 1'b0, "R8 pulses one cycle", 32'({irq, dma_off}), 32'd0);
    endtask

    task automatic run_read(input logic [31:0] a, input logic [2:0] code, input logic rate,
                            input logic own, input logic ie, input logic de, input logic rp);
        int d;
        int nw;
        logic [31:0] sa;
        d  = pace(rate, own);
        nw = (code == 3'd0) ? 0 : (code == 3'd7) ? 1 : ((256 << code) / 4);
        sa = eff_start(a);
        sec_owns = own; irq_en = ie; dma_en = de; dma_repeat = rp;
        issue_start(8'hB7, a, code, rate);
        chk(busy == 1'b1, "R3 read sets busy", 32'(busy), 32'd1);
        for (int k = 0; k < nw; k++) begin
            wait_word(d);
            chk(data_out == rom_word(sa + 32'(4 * k)), "R3 R4 word value", data_out, rom_word(sa + 32'(4 * k)));
            chk(rom_addr == sa + 32'(4 * k + 4), "R7 address step", rom_addr, sa + 32'(4 * k + 4));
            chk(dma_req == de, "R7 dma_req", 32'(dma_req), 32'(de));
            do_read();
        end
        wait_end(d, ie, de, rp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && word_ready == 0 && data_out == 0, "R1 reset outputs",
            {data_out[29:0], busy, word_ready}, 32'd0);
        chk(irq == 0 && dma_req == 0 && dma_off == 0, "R1 reset pulses",
            32'({irq, dma_req, dma_off}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R6: sweep of sizes and all four pacing combinations
        for (int r = 0; r < 2; r++)
            for (int o = 0; o < 2; o++)
                run_read(32'h0002_0000 + 32'(r * 32'h1000 + o * 32'h400), 3'd1,
                         r[0], o[0], 1'b1, 1'b1, 1'b0);
        run_read(32'h0001_0000, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        run_read(32'h0004_0000, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_read(32'h0000_9000, 3'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        run_read(32'h0000_9000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

        // R4 redirect boundaries
        run_read(32'h0000_1234, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_read(32'h0000_7FFF, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_read(32'h0000_8000, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_read(32'h0000_0000, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R5 chip ID
        sec_owns = 1'b0; irq_en = 1'b1; dma_en = 1'b0;
        issue_start(8'hB8, 32'h0001_0000, 3'd1, 1'b0);
        chk(word_ready == 1'b1 && busy == 1'b1, "R5 chip id ready", 32'({word_ready, busy}), 32'd3);
        chk(data_out == CHIP, "R5 chip id value", data_out, CHIP);
        do_read();
        wait_end(10, 1'b1, 1'b0, 1'b0);

        // R11 unknown opcode
        sec_owns = 1'b1; irq_en = 1'b1; dma_en = 1'b1; dma_repeat = 1'b0;
        issue_start(8'h9F, 32'h0001_0000, 3'd2, 1'b1);
        chk(busy == 1'b1 && word_ready == 1'b0, "R11 other opcode busy only", 32'({busy, word_ready}), 32'd2);
        wait_end(8, 1'b1, 1'b1, 1'b0);

        // R9 start ignored in serial mode
        spi_mode = 1'b1;
        issue_start(8'hB7, 32'h0001_0000, 3'd7, 1'b0);
        chk(busy == 1'b0, "R9 start ignored", 32'(busy), 32'd0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && word_ready == 1'b0, "R9 no word later", 32'({busy, word_ready}), 32'd0);
        spi_mode = 1'b0;

        // R10 restart while busy
        sec_owns = 1'b1; irq_en = 1'b1; dma_en = 1'b0;
        issue_start(8'hB7, 32'h0003_0000, 3'd1, 1'b0);
        for (int k = 0; k < 2; k++) begin
            wait_word(5);
            if (k == 0) do_read();
        end
        issue_start(8'hB7, 32'h0005_0000, 3'd7, 1'b0);
        chk(word_ready == 1'b0 && busy == 1'b1, "R10 restart clears ready", 32'({word_ready, busy}), 32'd1);
        wait_word(5);
        chk(data_out == rom_word(32'h0005_0000), "R10 restart word", data_out, rom_word(32'h0005_0000));
        do_read();
        wait_end(5, 1'b1, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule